// File: doc/BRIEF.md
# Configurable Thread Slot Scheduler

This block decides, on every clock cycle, which hardware thread may place an instruction into a shared single-issue pipeline. Three policies are selectable at run time.

- **Rotation:** each thread owns one cycle out of every N.
- **Slot table:** a programmable table of S entries names the owning thread of each cycle.
- **Priority:** the lowest-numbered thread that is ready wins.

In the two rotation-style policies an owner that is not ready costs a bubble; its cycle is never lent to another thread.

The chosen thread number leaves the block with the issue decision. A short tag pipeline carries the valid flag and the thread number alongside the instruction. Downstream stages can therefore select the matching per-thread state at a fixed later depth.

Both rotation counters run freely from reset in every policy. Table updates are staged in a shadow copy and become active only when a new pass over the table begins.

Top module: `tsched_top`

## Requirements
- R1: Synchronous active-high reset clears both rotation positions to 0, loads every slot entry i with thread i mod N_THR (shadow and active copies), and empties the tag pipeline (tag_valid low in the first cycle after reset).
- R2: With mode_sel = 0 (rotation), the owner in the k-th cycle after reset is thread k mod N_THR; iss_tid shows the owner, and iss_valid is high exactly when thr_ready[owner] is high.
- R3: In rotation mode, an owner that is not ready gives a bubble (iss_valid low, iss_tid still the owner), even if other threads are ready.
- R4: With mode_sel = 1 (slot table), the cycle k after reset uses active entry k mod N_SLOT; iss_tid is that entry, and iss_valid is high exactly when that thread is ready.
- R5: A write (tbl_wr_en with tbl_wr_idx, tbl_wr_tid) updates the shadow copy. The active copy takes the whole shadow, including a write in that same cycle, at the end of the cycle at slot position N_SLOT-1. A pass already in progress keeps its old entries.
- R6: With mode_sel = 2, the lowest-numbered ready thread issues.
- R7: In priority mode with no thread ready, the block emits a bubble with iss_tid = 0.
- R8: iss_bubble is always the inverse of iss_valid.
- R9: tag_valid and tag_tid repeat iss_valid and iss_tid exactly PIPE_DEPTH cycles later. While tag_valid is low, tag_tid is 0.
- R10: mode_sel = 3 behaves as priority mode. Both rotation positions advance every cycle whatever the mode, so switching into a rotation policy resumes at the position implied by the cycle count.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 0 rotation, 1 slot table, 2 or 3 priority |
| thr_ready | input | N_THR | Per-thread ready flags |
| tbl_wr_en | input | 1 | Slot table write strobe |
| tbl_wr_idx | input | log2(N_SLOT) | Slot entry to write |
| tbl_wr_tid | input | TID_W | Thread number stored in the entry |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_tid | output | TID_W | Selected thread number |
| iss_bubble | output | 1 | This cycle is a bubble |
| tag_valid | output | 1 | Valid flag PIPE_DEPTH cycles later |
| tag_tid | output | TID_W | Thread tag PIPE_DEPTH cycles later |

## Verification
A faulty rotation counter shows at once in iss_tid in rotation or table mode, and it stays wrong on every later cycle. A table entry that is corrupted or activated too early only shows when the pointer reaches that slot, at most N_SLOT cycles later. For that reason the bench writes entries in the middle of a pass and at its last slot, then compares each slot in the next two passes. An error in the tag pipeline shows at tag_valid and tag_tid PIPE_DEPTH cycles after the issue it affects.

// File: rtl/tsched_pkg.sv
package tsched_pkg;

    localparam int TSCHED_TID_W = 2;

    typedef enum logic [1:0] {
        MODE_ROT   = 2'd0,
        MODE_TABLE = 2'd1,
        MODE_PRIO  = 2'd2,
        MODE_PRIO2 = 2'd3
    } mode_e;

    typedef struct packed {
        logic                    valid;
        logic [TSCHED_TID_W-1:0] tid;
    } issue_t;

    function automatic logic [TSCHED_TID_W-1:0] ident_tid(input int slot, input int nthr);
        return TSCHED_TID_W'(slot % nthr);
    endfunction

endpackage

// File: rtl/tsched_ptr.sv
module tsched_ptr #(
    parameter int MODULUS = 4,
    localparam int PW = (MODULUS > 1) ? $clog2(MODULUS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] ptr,
    output logic          at_last
);
    assign at_last = (ptr == PW'(MODULUS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (at_last) begin
            ptr <= '0;
        end else begin
            ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/tsched_slot_tbl.sv
module tsched_slot_tbl
    import tsched_pkg::*;
#(
    parameter int N_SLOT = 8,
    parameter int N_THR  = 4,
    localparam int IW    = $clog2(N_SLOT),
    localparam int TW    = TSCHED_TID_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [TW-1:0] wr_tid,
    input  logic          commit,
    input  logic [IW-1:0] rd_idx,
    output logic [TW-1:0] rd_tid
);
    logic [TW-1:0] shadow [N_SLOT];
    logic [TW-1:0] active [N_SLOT];
    logic [TW-1:0] merged [N_SLOT];

    always_comb begin
        for (int i = 0; i < N_SLOT; i++) begin
            merged[i] = (wr_en && (wr_idx == IW'(i))) ? wr_tid : shadow[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_SLOT; i++) begin
                shadow[i] <= ident_tid(i, N_THR);
                active[i] <= ident_tid(i, N_THR);
            end
        end else begin
            for (int i = 0; i < N_SLOT; i++) begin
                shadow[i] <= merged[i];
                if (commit) begin
                    active[i] <= merged[i];
                end
            end
        end
    end

    assign rd_tid = active[rd_idx];
endmodule

// File: rtl/tsched_pick.sv
module tsched_pick
    import tsched_pkg::*;
#(
    parameter int N_THR = 4,
    localparam int TW   = TSCHED_TID_W
) (
    input  logic [N_THR-1:0] ready,
    output logic             found,
    output logic [TW-1:0]    tid
);
    always_comb begin
        found = 1'b0;
        tid   = '0;
        for (int i = N_THR - 1; i >= 0; i--) begin
            if (ready[i]) begin
                found = 1'b1;
                tid   = TW'(i);
            end
        end
    end
endmodule

// File: rtl/tsched_tag_pipe.sv
module tsched_tag_pipe
    import tsched_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  issue_t in_tag,
    output issue_t out_tag
);
    issue_t stage [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage[0] <= '0;
        end else begin
            stage[0] <= in_tag.valid ? in_tag : '0;
        end
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage[g] <= '0;
            end else begin
                stage[g] <= stage[g-1];
            end
        end
    end

    assign out_tag = stage[DEPTH-1];
endmodule

// File: rtl/tsched_top.sv
module tsched_top
    import tsched_pkg::*;
#(
    parameter int N_THR      = 4,
    parameter int N_SLOT     = 8,
    parameter int PIPE_DEPTH = 3,
    localparam int TID_W     = TSCHED_TID_W,
    localparam int SIW       = $clog2(N_SLOT),
    localparam int RPW       = (N_THR > 1) ? $clog2(N_THR) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic [N_THR-1:0] thr_ready,
    input  logic             tbl_wr_en,
    input  logic [SIW-1:0]   tbl_wr_idx,
    input  logic [TID_W-1:0] tbl_wr_tid,
    output logic             iss_valid,
    output logic [TID_W-1:0] iss_tid,
    output logic             iss_bubble,
    output logic             tag_valid,
    output logic [TID_W-1:0] tag_tid
);
    logic [RPW-1:0]   rot_ptr;
    logic             rot_last;
    logic [SIW-1:0]   slot_ptr;
    logic             slot_last;
    logic [TID_W-1:0] tbl_tid;
    logic             pick_found;
    logic [TID_W-1:0] pick_tid;
    issue_t           cur, tail;
    mode_e            mode;

    tsched_ptr #(.MODULUS(N_THR)) u_rot (
        .clk(clk), .rst(rst), .ptr(rot_ptr), .at_last(rot_last)
    );

    tsched_ptr #(.MODULUS(N_SLOT)) u_slot (
        .clk(clk), .rst(rst), .ptr(slot_ptr), .at_last(slot_last)
    );

    tsched_slot_tbl #(.N_SLOT(N_SLOT), .N_THR(N_THR)) u_tbl (
        .clk(clk), .rst(rst),
        .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_tid(tbl_wr_tid),
        .commit(slot_last), .rd_idx(slot_ptr), .rd_tid(tbl_tid)
    );

    tsched_pick #(.N_THR(N_THR)) u_pick (
        .ready(thr_ready), .found(pick_found), .tid(pick_tid)
    );

    assign mode = mode_e'(mode_sel);

    always_comb begin
        cur = '0;
        unique case (mode)
            MODE_ROT: begin
                cur.tid   = TID_W'(rot_ptr);
                cur.valid = thr_ready[rot_ptr];
            end
            MODE_TABLE: begin
                cur.tid   = tbl_tid;
                cur.valid = (int'(tbl_tid) < N_THR) && thr_ready[tbl_tid];
            end
            default: begin
                cur.tid   = pick_tid;
                cur.valid = pick_found;
            end
        endcase
    end

    tsched_tag_pipe #(.DEPTH(PIPE_DEPTH)) u_tag (
        .clk(clk), .rst(rst), .in_tag(cur), .out_tag(tail)
    );

    assign iss_valid  = cur.valid;
    assign iss_tid    = cur.tid;
    assign iss_bubble = ~cur.valid;
    assign tag_valid  = tail.valid;
    assign tag_tid    = tail.tid;

    logic unused_rot_last;
    assign unused_rot_last = rot_last;
endmodule

// File: rtl/tsched_chk.sv
module tsched_chk #(
    parameter int N_THR = 4,
    parameter int TID_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode_sel,
    input logic [N_THR-1:0] thr_ready,
    input logic             iss_valid,
    input logic [TID_W-1:0] iss_tid,
    input logic             iss_bubble
);
    AST_BUBBLE_INVERSE: assert property (@(posedge clk) disable iff (rst)
        iss_bubble == !iss_valid); // R8

    AST_ISSUE_IS_READY: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> thr_ready[iss_tid]); // R4

    AST_ROT_STEP: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'd0 && $past(mode_sel) == 2'd0 && !$past(rst))
        |-> (int'(iss_tid) == (int'($past(iss_tid)) + 1) % N_THR)); // R2

    AST_ROT_NO_LEND: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'd0 && !thr_ready[iss_tid]) |-> iss_bubble); // R3

    AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (rst)
        (mode_sel[1] && iss_valid)
        |-> ((thr_ready & ((N_THR'(1) << iss_tid) - N_THR'(1))) == '0)); // R6

    AST_PRIO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (mode_sel[1] && thr_ready == '0) |-> (iss_bubble && iss_tid == '0)); // R7
endmodule

bind tsched_top tsched_chk #(.N_THR(N_THR), .TID_W(TID_W)) u_chk (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .thr_ready(thr_ready),
    .iss_valid(iss_valid), .iss_tid(iss_tid), .iss_bubble(iss_bubble)
);

// File: tb/sim_tsched_top.sv
module sim_tsched_top;
    localparam int NT = 4;
    localparam int NS = 8;
    localparam int PD = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode_sel = 2'd0;
    logic [NT-1:0] thr_ready = '0;
    logic          tbl_wr_en = 1'b0;
    logic [2:0]    tbl_wr_idx = '0;
    logic [1:0]    tbl_wr_tid = '0;
    logic          iss_valid, iss_bubble, tag_valid;
    logic [1:0]    iss_tid, tag_tid;

    int checks = 0;
    int failures = 0;

    // reference state built from the requirements
    int cyc = 0;
    int sh [NS];
    int ac [NS];
    int hv [PD];
    int ht [PD];

    tsched_top #(.N_THR(NT), .N_SLOT(NS), .PIPE_DEPTH(PD)) u0 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .thr_ready(thr_ready),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_tid(tbl_wr_tid),
        .iss_valid(iss_valid), .iss_tid(iss_tid), .iss_bubble(iss_bubble),
        .tag_valid(tag_valid), .tag_tid(tag_tid)
    );

    always #10ns clk = ~clk;

    function automatic void expect_issue(output int ev, output int et);
        ev = 0;
        et = 0;
        if (mode_sel == 2'd0) begin
            et = cyc % NT;
            ev = int'(thr_ready[et]);
        end else if (mode_sel == 2'd1) begin
            et = ac[cyc % NS];
            ev = int'(thr_ready[et]);
        end else begin
            for (int i = NT - 1; i >= 0; i--) begin
                if (thr_ready[i]) begin
                    ev = 1;
                    et = i;
                end
            end
        end
    endfunction

    always @(posedge clk) begin
        int ev, et;
        if (rst) begin
            cyc = 0;
            for (int i = 0; i < NS; i++) begin
                sh[i] = i % NT;
                ac[i] = i % NT;
            end
            for (int d = 0; d < PD; d++) begin
                hv[d] = 0;
                ht[d] = 0;
            end
        end else begin
            expect_issue(ev, et);
            for (int d = PD - 1; d > 0; d--) begin
                hv[d] = hv[d-1];
                ht[d] = ht[d-1];
            end
            hv[0] = ev;
            ht[0] = ev ? et : 0;
            if (tbl_wr_en) sh[tbl_wr_idx] = int'(tbl_wr_tid);
            if (cyc % NS == NS - 1) begin
                for (int i = 0; i < NS; i++) ac[i] = sh[i];
            end
            cyc = cyc + 1;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // one cycle: drive at the falling edge, compare before the next rising edge
    task automatic step(input string req, input logic [1:0] m, input logic [NT-1:0] rdy,
                        input logic we, input int widx, input int wtid);
        int ev, et;
        @(negedge clk);
        mode_sel   = m;
        thr_ready  = rdy;
        tbl_wr_en  = we;
        tbl_wr_idx = 3'(widx);
        tbl_wr_tid = 2'(wtid);
        #1ns;
        expect_issue(ev, et);
        check(req, "iss_valid", int'(iss_valid), ev);
        check(req, "iss_tid", int'(iss_tid), et);
        check("R8", "iss_bubble", int'(iss_bubble), 1 - ev);
        check("R9", "tag_valid", int'(tag_valid), hv[PD-1]);
        check("R9", "tag_tid", int'(tag_tid), ht[PD-1]);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        tbl_wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1ns;
        check("R1", "tag_valid after reset", int'(tag_valid), 0);
        check("R1", "tag_tid after reset", int'(tag_tid), 0);
        check("R1", "rotation position after reset", int'(iss_tid), 0);
    endtask

    task automatic t_reset_table();
        t_reset();
        for (int k = 0; k < NS; k++) step("R1", 2'd1, 4'b1111, 1'b0, 0, 0);
    endtask

    task automatic t_rotation();
        t_reset();
        for (int k = 0; k < 8; k++) step("R2", 2'd0, 4'b1111, 1'b0, 0, 0);
        for (int k = 0; k < 8; k++) step("R3", 2'd0, 4'b1010, 1'b0, 0, 0);
        for (int k = 0; k < 4; k++) step("R3", 2'd0, 4'b0000, 1'b0, 0, 0);
        for (int k = 0; k < 6; k++) step("R2", 2'd0, 4'b0100, 1'b0, 0, 0);
    endtask

    task automatic t_table();
        t_reset();
        step("R4", 2'd1, 4'b1111, 1'b0, 0, 0);
        step("R4", 2'd1, 4'b1111, 1'b0, 0, 0);
        step("R5", 2'd1, 4'b1111, 1'b1, 5, 3);
        step("R5", 2'd1, 4'b1111, 1'b1, 6, 3);
        for (int k = 0; k < 3; k++) step("R5", 2'd1, 4'b1111, 1'b0, 0, 0);
        step("R5", 2'd1, 4'b1111, 1'b1, 0, 2);
        for (int k = 0; k < NS; k++) step("R5", 2'd1, 4'b1111, 1'b0, 0, 0);
        for (int k = 0; k < NS; k++) step("R4", 2'd1, 4'b0110, 1'b0, 0, 0);
        for (int k = 0; k < NS; k++) step("R4", 2'd1, 4'b1001, 1'b1, k, 3 - (k % 4));
        for (int k = 0; k < NS * 2; k++) step("R5", 2'd1, 4'b1101, 1'b0, 0, 0);
    endtask

    task automatic t_priority();
        t_reset();
        for (int r = 0; r < 16; r++) step("R6", 2'd2, 4'(r), 1'b0, 0, 0);
        step("R7", 2'd2, 4'b0000, 1'b0, 0, 0);
        step("R7", 2'd2, 4'b0000, 1'b0, 0, 0);
        for (int r = 15; r >= 0; r--) step("R10", 2'd3, 4'(r), 1'b0, 0, 0);
    endtask

    task automatic t_switch();
        t_reset();
        for (int k = 0; k < 3; k++) step("R10", 2'd2, 4'b1000, 1'b0, 0, 0);
        for (int k = 0; k < 5; k++) step("R10", 2'd0, 4'b1111, 1'b0, 0, 0);
        for (int k = 0; k < 5; k++) step("R10", 2'd1, 4'b1111, 1'b0, 0, 0);
        for (int k = 0; k < 7; k++) step("R9", 2'(k % 3), 4'(k * 5), 1'b0, 0, 0);
    endtask

    initial begin : watchdog
        #(20ns * 100000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        t_reset_table();
        t_rotation();
        t_table();
        t_priority();
        t_switch();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule